// File: doc/BRIEF.md
# Dual-Engine Flow Lookup

This block classifies one packet per cycle. It takes a header that has already been parsed and forms a 271-bit flow key from twelve fields. The twelve are the usual ten-field flow tuple plus the 20-bit label values of the outer and inner label-stack entries. Two engines search with the same key at the same time:

- An exact-match table of 32 entries, probed at two slots chosen by two CRC hashes.
- A ternary table of 32 masked entries. The top 8 slots of this table hold fixed per-port default rules. Misses from the physical ports go to the paired host DMA port, and traffic from the DMA ports goes back to the paired physical port.

An arbiter merges the two results into a single entry index and action. It always prefers an exact hit. The counter of the chosen entry is incremented, and its new value is reported with the result.

Software programs both tables through a single-cycle write port. For the exact table, software computes the hash and writes the entry at the slot it has picked. Ingress ports 0 to 3 are physical ports and 4 to 7 are DMA ports.

Top module: `flow_lookup`

## Requirements
- R1: Key layout and latency.
  - The key is, MSB first: in_port(3), mac_dst(48), mac_src(48), eth_type(16), vlan_id(12), ip_src(32), ip_dst(32), ip_proto(8), l4_src(16), l4_dst(16), outer label(20), inner label(20).
  - A key sampled with key_valid_i at a rising edge gives res_valid_o high after the second rising edge.
  - A new key is accepted every cycle.
- R2: Exact hit rule.
  - Slot h1 is the CRC-5 of the key with polynomial 0x05. Slot h2 is the CRC-5 with polynomial 0x09. Both use a zero initial value and process the key MSB first.
  - A valid entry at h1 or h2 whose stored key equals all 271 key bits is an exact hit.
  - h1 is checked first.
  - A hit reports res_exact_o=1, res_miss_o=0, the slot on res_idx_o and its stored action.
- R3: An exact hit is selected even when wildcard entries also match.
- R4: Wildcard rule.
  - A wildcard user entry matches when every key bit whose mask bit is 1 equals the stored bit.
  - Among matching valid entries, the lowest index wins.
  - A user wildcard result reports res_exact_o=0 and res_miss_o=0.
- R5: Only bits 31:12 of each 32-bit label-stack input take part in the lookup. Bits 11:0 never change the result.
- R6: Default slots.
  - Slot 24+p matches any key with in_port p.
  - Its action is p XOR 4, zero-extended.
  - It reports res_miss_o=1.
  - A default slot is chosen only when neither the exact table nor any user wildcard entry hits.
- R7: Wildcard writes to indices 24 to 31 are ignored. They change neither the default rules nor their counters.
- R8: Counters.
  - Each slot of each table has a hit counter.
  - Only the selected entry is incremented.
  - res_cnt_o reports its value including the current packet, so back-to-back packets see consecutive counts.
- R9: Writing an entry.
  - A write with wr_en_i replaces the entry's key, mask and action and clears its counter.
  - wr_tbl_i=0 selects the exact table and 1 selects the wildcard table.
  - wr_vld_i=0 invalidates the entry.
- R10: A lookup whose compare cycle ends at the same edge as a write sees the contents before that write. When both touch the same counter, the clear wins.
- R11: After reset:
  - all user entries are invalid;
  - all counters are zero;
  - res_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_valid_i | input | 1 | Header fields valid this cycle |
| in_port_i | input | 3 | Ingress port, 0-3 physical, 4-7 DMA |
| mac_dst_i | input | 48 | Destination MAC |
| mac_src_i | input | 48 | Source MAC |
| eth_type_i | input | 16 | EtherType |
| vlan_id_i | input | 12 | VLAN id |
| ip_src_i | input | 32 | Source IP |
| ip_dst_i | input | 32 | Destination IP |
| ip_proto_i | input | 8 | IP protocol |
| l4_src_i | input | 16 | L4 source port |
| l4_dst_i | input | 16 | L4 destination port |
| mpls_outer_i | input | 32 | Outer label-stack entry, label in 31:12 |
| mpls_inner_i | input | 32 | Inner label-stack entry, label in 31:12 |
| wr_en_i | input | 1 | Table write strobe |
| wr_tbl_i | input | 1 | 0 exact, 1 wildcard |
| wr_idx_i | input | 5 | Slot to write |
| wr_vld_i | input | 1 | Valid bit written with the entry |
| wr_key_i | input | 271 | Entry key in the R1 layout |
| wr_mask_i | input | 271 | Wildcard compare mask, 1 = compare |
| wr_act_i | input | 16 | Entry action |
| res_valid_o | output | 1 | Result valid |
| res_exact_o | output | 1 | Result came from the exact table |
| res_miss_o | output | 1 | Result is a default (host) rule |
| res_idx_o | output | 5 | Selected slot in its table |
| res_act_o | output | 16 | Selected action |
| res_cnt_o | output | 16 | Counter of the selected slot after this hit |

## Verification
The case that needs care is a table write and a lookup that lands on the same entry at the same edge. In that case the entry contents and its counter are both updated by the write and read by the lookup.

The bench provokes this case in two ways:
- A directed step issues the write one cycle after the key, so that both meet at one edge, and covers both invalidation and rewrite of the same key.
- The random stream mixes writes with a key every cycle.

A reference model predicts each earlier key before it applies the write, and predicts the key that follows after the write. From that ordering it expects:
- the old entry in the result;
- a cleared counter for the next packet.

// File: rtl/flow_lkup_pkg.sv
package flow_lkup_pkg;
  localparam int PORT_W  = 3;
  localparam int MAC_W   = 48;
  localparam int ETYPE_W = 16;
  localparam int VLAN_W  = 12;
  localparam int IP_W    = 32;
  localparam int PROTO_W = 8;
  localparam int L4_W    = 16;
  localparam int LBL_W   = 20;
  localparam int STK_W   = 32;

  // field order is the hash input order
  typedef struct packed {
    logic [PORT_W-1:0]  in_port;
    logic [MAC_W-1:0]   mac_dst;
    logic [MAC_W-1:0]   mac_src;
    logic [ETYPE_W-1:0] eth_type;
    logic [VLAN_W-1:0]  vlan_id;
    logic [IP_W-1:0]    ip_src;
    logic [IP_W-1:0]    ip_dst;
    logic [PROTO_W-1:0] ip_proto;
    logic [L4_W-1:0]    l4_src;
    logic [L4_W-1:0]    l4_dst;
    logic [LBL_W-1:0]   lbl_outer;
    logic [LBL_W-1:0]   lbl_inner;
  } flow_key_t;

  localparam int KEY_W = $bits(flow_key_t);
endpackage

// File: rtl/flow_key_hash.sv
module flow_key_hash #(
  parameter int          KW   = 271,
  parameter int          HW   = 5,
  parameter int unsigned POLY = 5
) (
  input  logic [KW-1:0] key_i,
  output logic [HW-1:0] hash_o
);
  localparam logic [HW-1:0] POLY_V = HW'(POLY);

  logic [HW-1:0] crc;
  logic          fb;

  always_comb begin
    crc = '0;
    fb  = 1'b0;
    for (int b = KW - 1; b >= 0; b--) begin
      fb  = crc[HW-1] ^ key_i[b];
      crc = {crc[HW-2:0], 1'b0} ^ (fb ? POLY_V : '0);
    end
    hash_o = crc;
  end
endmodule

// File: rtl/flow_exact_tbl.sv
module flow_exact_tbl
  import flow_lkup_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int ACT_W = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic             wr_vld_i,
  input  flow_key_t        wr_key_i,
  input  logic [ACT_W-1:0] wr_act_i,
  input  flow_key_t        key_i,
  input  logic [IW-1:0]    h1_i,
  input  logic [IW-1:0]    h2_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o,
  output logic [ACT_W-1:0] act_o
);
  logic [DEPTH-1:0] vld_q;
  flow_key_t        key_q [DEPTH];
  logic [ACT_W-1:0] act_q [DEPTH];
  logic             hit1, hit2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      vld_q <= '0;
    else if (wr_en_i) vld_q[wr_idx_i] <= wr_vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      key_q[wr_idx_i] <= wr_key_i;
      act_q[wr_idx_i] <= wr_act_i;
    end
  end

  assign hit1  = vld_q[h1_i] && (key_q[h1_i] == key_i);
  assign hit2  = vld_q[h2_i] && (key_q[h2_i] == key_i);
  assign hit_o = hit1 | hit2;
  assign idx_o = hit1 ? h1_i : h2_i;
  assign act_o = act_q[idx_o];
endmodule

// File: rtl/flow_wild_tbl.sv
module flow_wild_tbl
  import flow_lkup_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int ACT_W     = 16,
  localparam int IW       = $clog2(DEPTH),
  localparam int N_DEF    = 2 ** PORT_W,
  localparam int DEF_BASE = DEPTH - N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IW-1:0]    wr_idx_i,
  input  logic             wr_vld_i,
  input  flow_key_t        wr_key_i,
  input  logic [KEY_W-1:0] wr_mask_i,
  input  logic [ACT_W-1:0] wr_act_i,
  input  flow_key_t        key_i,
  output logic             hit_o,
  output logic [IW-1:0]    idx_o,
  output logic [ACT_W-1:0] act_o
);
  logic                wr_ok;
  logic [DEF_BASE-1:0] vld_q;
  flow_key_t           key_q  [DEF_BASE];
  logic [KEY_W-1:0]    mask_q [DEF_BASE];
  logic [ACT_W-1:0]    uact_q [DEF_BASE];
  logic [DEPTH-1:0]    match;
  logic [ACT_W-1:0]    slot_act [DEPTH];

  // reserved default slots are never writable
  assign wr_ok = wr_en_i && (int'(wr_idx_i) < DEF_BASE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    vld_q <= '0;
    else if (wr_ok) vld_q[wr_idx_i] <= wr_vld_i;
  end

  always_ff @(posedge clk_i) begin
    if (wr_ok) begin
      key_q[wr_idx_i]  <= wr_key_i;
      mask_q[wr_idx_i] <= wr_mask_i;
      uact_q[wr_idx_i] <= wr_act_i;
    end
  end

  for (genvar g = 0; g < DEF_BASE; g++) begin : g_user
    assign match[g]    = vld_q[g] && (((key_i ^ key_q[g]) & mask_q[g]) == '0);
    assign slot_act[g] = uact_q[g];
  end

  for (genvar p = 0; p < N_DEF; p++) begin : g_def
    assign match[DEF_BASE+p]    = (int'(key_i.in_port) == p);
    assign slot_act[DEF_BASE+p] = ACT_W'(p ^ (N_DEF / 2));
  end

  // lowest index wins
  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    act_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o = 1'b1;
        idx_o = IW'(i);
        act_o = slot_act[i];
      end
    end
  end
endmodule

// File: rtl/flow_hit_cnt.sv
module flow_hit_cnt #(
  parameter int DEPTH = 32,
  parameter int CNT_W = 16,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [IW-1:0]    inc_idx_i,
  input  logic             clr_i,
  input  logic [IW-1:0]    clr_idx_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q [DEPTH];

  assign cnt_o = cnt_q[inc_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cnt_q[i] <= '0;
    end else begin
      if (inc_i) cnt_q[inc_idx_i] <= cnt_o + 1'b1;
      if (clr_i) cnt_q[clr_idx_i] <= '0;  // clear beats increment
    end
  end

  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !(clr_i && clr_idx_i == inc_idx_i)
      |=> cnt_q[$past(inc_idx_i)] == $past(cnt_o) + 1'b1);  // R8

  AST_CNT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q[$past(clr_idx_i)] == '0);  // R10
endmodule

// File: rtl/flow_lookup.sv
module flow_lookup
  import flow_lkup_pkg::*;
#(
  parameter int          EX_DEPTH = 32,
  parameter int          WC_DEPTH = 32,
  parameter int          ACT_W    = 16,
  parameter int          CNT_W    = 16,
  parameter int unsigned H1_POLY  = 5,
  parameter int unsigned H2_POLY  = 9,
  localparam int EX_IW = $clog2(EX_DEPTH),
  localparam int WC_IW = $clog2(WC_DEPTH),
  localparam int IDX_W = (EX_IW > WC_IW) ? EX_IW : WC_IW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               key_valid_i,
  input  logic [PORT_W-1:0]  in_port_i,
  input  logic [MAC_W-1:0]   mac_dst_i,
  input  logic [MAC_W-1:0]   mac_src_i,
  input  logic [ETYPE_W-1:0] eth_type_i,
  input  logic [VLAN_W-1:0]  vlan_id_i,
  input  logic [IP_W-1:0]    ip_src_i,
  input  logic [IP_W-1:0]    ip_dst_i,
  input  logic [PROTO_W-1:0] ip_proto_i,
  input  logic [L4_W-1:0]    l4_src_i,
  input  logic [L4_W-1:0]    l4_dst_i,
  input  logic [STK_W-1:0]   mpls_outer_i,
  input  logic [STK_W-1:0]   mpls_inner_i,
  input  logic               wr_en_i,
  input  logic               wr_tbl_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic               wr_vld_i,
  input  logic [KEY_W-1:0]   wr_key_i,
  input  logic [KEY_W-1:0]   wr_mask_i,
  input  logic [ACT_W-1:0]   wr_act_i,
  output logic               res_valid_o,
  output logic               res_exact_o,
  output logic               res_miss_o,
  output logic [IDX_W-1:0]   res_idx_o,
  output logic [ACT_W-1:0]   res_act_o,
  output logic [CNT_W-1:0]   res_cnt_o
);
  localparam int N_DEF    = 2 ** PORT_W;
  localparam int DEF_BASE = WC_DEPTH - N_DEF;

  flow_key_t        in_key, s0_key;
  logic             s0_vld;
  logic [EX_IW-1:0] h1, h2, ex_idx;
  logic [WC_IW-1:0] wc_idx;
  logic             ex_hit, wc_hit;
  logic [ACT_W-1:0] ex_act, wc_act;
  logic [CNT_W-1:0] ex_cnt, wc_cnt;
  logic             ex_wr, wc_wr, wc_clr;
  logic             unused_bits;

  assign in_key = '{in_port: in_port_i, mac_dst: mac_dst_i, mac_src: mac_src_i,
                    eth_type: eth_type_i, vlan_id: vlan_id_i, ip_src: ip_src_i,
                    ip_dst: ip_dst_i, ip_proto: ip_proto_i, l4_src: l4_src_i,
                    l4_dst: l4_dst_i,
                    lbl_outer: mpls_outer_i[STK_W-1 -: LBL_W],
                    lbl_inner: mpls_inner_i[STK_W-1 -: LBL_W]};
  // qos, bottom-of-stack and ttl bits stay out of the key
  assign unused_bits = ^{mpls_outer_i[STK_W-LBL_W-1:0], mpls_inner_i[STK_W-LBL_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s0_vld <= 1'b0;
      s0_key <= '0;
    end else begin
      s0_vld <= key_valid_i;
      s0_key <= in_key;
    end
  end

  flow_key_hash #(.KW(KEY_W), .HW(EX_IW), .POLY(H1_POLY)) i_hash1 (
    .key_i(s0_key), .hash_o(h1));
  flow_key_hash #(.KW(KEY_W), .HW(EX_IW), .POLY(H2_POLY)) i_hash2 (
    .key_i(s0_key), .hash_o(h2));

  assign ex_wr  = wr_en_i && !wr_tbl_i;
  assign wc_wr  = wr_en_i && wr_tbl_i;
  assign wc_clr = wc_wr && (int'(wr_idx_i) < DEF_BASE);

  flow_exact_tbl #(.DEPTH(EX_DEPTH), .ACT_W(ACT_W)) i_exact (
    .clk_i, .rst_ni,
    .wr_en_i(ex_wr), .wr_idx_i(wr_idx_i[EX_IW-1:0]), .wr_vld_i,
    .wr_key_i(flow_key_t'(wr_key_i)), .wr_act_i,
    .key_i(s0_key), .h1_i(h1), .h2_i(h2),
    .hit_o(ex_hit), .idx_o(ex_idx), .act_o(ex_act));

  flow_wild_tbl #(.DEPTH(WC_DEPTH), .ACT_W(ACT_W)) i_wild (
    .clk_i, .rst_ni,
    .wr_en_i(wc_wr), .wr_idx_i(wr_idx_i[WC_IW-1:0]), .wr_vld_i,
    .wr_key_i(flow_key_t'(wr_key_i)), .wr_mask_i, .wr_act_i,
    .key_i(s0_key),
    .hit_o(wc_hit), .idx_o(wc_idx), .act_o(wc_act));

  flow_hit_cnt #(.DEPTH(EX_DEPTH), .CNT_W(CNT_W)) i_ex_cnt (
    .clk_i, .rst_ni,
    .inc_i(s0_vld && ex_hit), .inc_idx_i(ex_idx),
    .clr_i(ex_wr), .clr_idx_i(wr_idx_i[EX_IW-1:0]),
    .cnt_o(ex_cnt));

  flow_hit_cnt #(.DEPTH(WC_DEPTH), .CNT_W(CNT_W)) i_wc_cnt (
    .clk_i, .rst_ni,
    .inc_i(s0_vld && !ex_hit && wc_hit), .inc_idx_i(wc_idx),
    .clr_i(wc_clr), .clr_idx_i(wr_idx_i[WC_IW-1:0]),
    .cnt_o(wc_cnt));

  // arbiter: exact always beats wildcard
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_exact_o <= 1'b0;
      res_miss_o  <= 1'b0;
      res_idx_o   <= '0;
      res_act_o   <= '0;
      res_cnt_o   <= '0;
    end else begin
      res_valid_o <= s0_vld;
      if (s0_vld) begin
        res_exact_o <= ex_hit;
        res_miss_o  <= !ex_hit && (int'(wc_idx) >= DEF_BASE);
        res_idx_o   <= ex_hit ? IDX_W'(ex_idx) : IDX_W'(wc_idx);
        res_act_o   <= ex_hit ? ex_act : wc_act;
        res_cnt_o   <= (ex_hit ? ex_cnt : wc_cnt) + 1'b1;
      end
    end
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_valid_i |-> ##2 res_valid_o);  // R1

  AST_EXACT_NOT_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_exact_o |-> !res_miss_o);  // R3

  AST_DEFAULT_ACTION: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_miss_o
      |-> res_act_o == ACT_W'((int'(res_idx_o) - DEF_BASE) ^ (N_DEF / 2)));  // R6
endmodule

// File: tb/test_flow_lookup.sv
module test_flow_lookup;
  localparam int KW = 271;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          key_valid = 1'b0;
  logic [KW-1:0] tk = '0;
  logic [11:0]   lo_o = '0, lo_i = '0;
  logic          wr_en = 1'b0, wr_tbl = 1'b0, wr_vld = 1'b0;
  logic [4:0]    wr_idx = '0;
  logic [KW-1:0] wr_key = '0, wr_mask = '0;
  logic [15:0]   wr_act = '0;
  logic          res_valid, res_exact, res_miss;
  logic [4:0]    res_idx;
  logic [15:0]   res_act, res_cnt;

  flow_lookup i_flow_lookup (
    .clk_i(clk), .rst_ni(rst_n), .key_valid_i(key_valid),
    .in_port_i(tk[270:268]), .mac_dst_i(tk[267:220]), .mac_src_i(tk[219:172]),
    .eth_type_i(tk[171:156]), .vlan_id_i(tk[155:144]), .ip_src_i(tk[143:112]),
    .ip_dst_i(tk[111:80]), .ip_proto_i(tk[79:72]), .l4_src_i(tk[71:56]),
    .l4_dst_i(tk[55:40]), .mpls_outer_i({tk[39:20], lo_o}),
    .mpls_inner_i({tk[19:0], lo_i}),
    .wr_en_i(wr_en), .wr_tbl_i(wr_tbl), .wr_idx_i(wr_idx), .wr_vld_i(wr_vld),
    .wr_key_i(wr_key), .wr_mask_i(wr_mask), .wr_act_i(wr_act),
    .res_valid_o(res_valid), .res_exact_o(res_exact), .res_miss_o(res_miss),
    .res_idx_o(res_idx), .res_act_o(res_act), .res_cnt_o(res_cnt));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // reference model
  logic [KW-1:0] m_ek [32];
  logic [15:0]   m_ea [32];
  logic          m_ev [32];
  logic [KW-1:0] m_wk [24], m_wm [24];
  logic [15:0]   m_wa [24];
  logic          m_wv [24];
  logic [15:0]   m_ec [32], m_wc [32];

  localparam logic [KW-1:0] M_PORT  = {3'b111, 268'd0};
  localparam logic [KW-1:0] M_ETYPE = {{(KW-172){1'b0}}, 16'hffff, 156'd0};
  localparam logic [KW-1:0] M_VLAN  = {{(KW-156){1'b0}}, 12'hfff, 144'd0};
  localparam logic [KW-1:0] M_PROTO = {{(KW-80){1'b0}}, 8'hff, 72'd0};

  function automatic logic [4:0] crc5(input logic [KW-1:0] k, input logic [4:0] poly);
    logic [4:0] r = '0;
    for (int b = KW - 1; b >= 0; b--)
      r = (r[4] ^ k[b]) ? ({r[3:0], 1'b0} ^ poly) : {r[3:0], 1'b0};
    return r;
  endfunction

  function automatic logic [KW-1:0] rnd_key();
    logic [287:0] t;
    for (int w = 0; w < 9; w++) t[w*32 +: 32] = $urandom;
    return t[KW-1:0];
  endfunction

  function automatic void m_wr_ex(input int i, input logic [KW-1:0] k,
                                  input logic [15:0] a, input logic v);
    m_ek[i] = k; m_ea[i] = a; m_ev[i] = v; m_ec[i] = '0;
  endfunction

  function automatic void m_wr_wc(input int i, input logic [KW-1:0] k, input logic [KW-1:0] m,
                                  input logic [15:0] a, input logic v);
    if (i < 24) begin
      m_wk[i] = k; m_wm[i] = m; m_wa[i] = a; m_wv[i] = v; m_wc[i] = '0;
    end
  endfunction

  // {valid, exact, miss, idx, act, cnt}
  function automatic logic [39:0] predict(input logic [KW-1:0] k);
    logic [4:0] a = crc5(k, 5'h05);
    logic [4:0] b = crc5(k, 5'h09);
    logic [4:0] p;
    if (m_ev[a] && m_ek[a] == k) begin
      m_ec[a]++;
      return {3'b110, a, m_ea[a], m_ec[a]};
    end
    if (m_ev[b] && m_ek[b] == k) begin
      m_ec[b]++;
      return {3'b110, b, m_ea[b], m_ec[b]};
    end
    for (int i = 0; i < 24; i++) begin
      if (m_wv[i] && ((k ^ m_wk[i]) & m_wm[i]) == '0) begin
        m_wc[i]++;
        return {3'b100, 5'(i), m_wa[i], m_wc[i]};
      end
    end
    p = 5'd24 + 5'(k[270:268]);
    m_wc[p]++;
    return {3'b101, p, 13'd0, k[270:268] ^ 3'd4, m_wc[p]};
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] dut_res();
    return {res_valid, res_exact, res_miss, res_idx, res_act, res_cnt};
  endfunction

  task automatic prog(input logic tbl, input int i, input logic [KW-1:0] k,
                      input logic [KW-1:0] m, input logic [15:0] a, input logic v);
    @(negedge clk);
    wr_en = 1'b1; wr_tbl = tbl; wr_idx = 5'(i); wr_key = k; wr_mask = m;
    wr_act = a; wr_vld = v;
    if (tbl) m_wr_wc(i, k, m, a, v); else m_wr_ex(i, k, a, v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic look(input string req, input logic [KW-1:0] k,
                      input logic [11:0] lo = '0, input logic [11:0] li = '0);
    logic [39:0] e;
    @(negedge clk);
    tk = k; lo_o = lo; lo_i = li; key_valid = 1'b1;
    e = predict(k);
    @(negedge clk);
    key_valid = 1'b0;
    @(negedge clk);
    chk(req, dut_res(), e);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [KW-1:0] k0, k1, kr;
  logic [KW-1:0] pool [8];
  logic [39:0]   ex [400];
  logic [4:0]    ha, hb;

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 32; i++) begin
      m_ev[i] = 0; m_ec[i] = '0; m_wc[i] = '0; m_ek[i] = '0; m_ea[i] = '0;
    end
    for (int i = 0; i < 24; i++) begin
      m_wv[i] = 0; m_wk[i] = '0; m_wm[i] = '0; m_wa[i] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R11 valid low in reset", {39'd0, res_valid}, 40'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 valid low after reset", {39'd0, res_valid}, 40'd0);
    look("R11 first lookup default count 1", rnd_key());

    // R6 every ingress port hits its own default slot
    for (int p = 0; p < 8; p++) begin
      kr = rnd_key(); kr[270:268] = 3'(p);
      look("R6 default per port", kr);
    end

    // R2 key with distinct hash slots
    do begin k0 = rnd_key(); k0[270:268] = 3'd1; end
    while (crc5(k0, 5'h05) == crc5(k0, 5'h09));
    ha = crc5(k0, 5'h05); hb = crc5(k0, 5'h09);
    prog(1'b0, hb, k0, '0, 16'h0b0b, 1'b1);
    look("R2 hit at second hash slot", k0);
    prog(1'b0, ha, k0, '0, 16'h0a0a, 1'b1);
    look("R2 first hash slot checked first", k0);
    look("R8 count advances", k0);

    // R3 exact wins over a full-mask wildcard match
    prog(1'b1, 0, k0, {KW{1'b1}}, 16'h1111, 1'b1);
    look("R3 exact beats wildcard", k0);
    prog(1'b1, 5, k0, M_PORT, 16'h5555, 1'b1);
    prog(1'b0, ha, k0, '0, 16'h0, 1'b0);
    prog(1'b0, hb, k0, '0, 16'h0, 1'b0);
    look("R4 lowest wildcard index wins", k0);
    prog(1'b1, 0, k0, '0, 16'h0, 1'b0);
    look("R4 next wildcard after invalidate", k0);

    // R5 low label-stack bits ignored, label bits significant
    prog(1'b0, ha, k0, '0, 16'h0c0c, 1'b1);
    look("R5 low stack bits ignored", k0, 12'hfff, 12'h5a5);
    k1 = k0; k1[0] = ~k1[0];
    look("R5 label bit changes result", k1);

    // R9 rewrite clears counter; invalidate drops hit
    look("R8 count again", k0);
    prog(1'b0, ha, k0, '0, 16'h0d0d, 1'b1);
    look("R9 rewrite restarts count", k0);

    // R7 writes to reserved slots ignored
    prog(1'b1, 26, '0, '0, 16'hbeef, 1'b1);
    prog(1'b1, 30, '0, '0, 16'hdead, 1'b1);
    kr = rnd_key(); kr[270:268] = 3'd2;
    look("R7 reserved slot keeps default and count", kr);
    kr = rnd_key(); kr[270:268] = 3'd6;
    look("R7 reserved DMA slot untouched", kr);

    // R10 write meets lookup at the same edge: invalidate
    @(negedge clk);
    tk = k0; lo_o = '0; lo_i = '0; key_valid = 1'b1;
    ex[0] = predict(k0);
    @(negedge clk);
    key_valid = 1'b0;
    wr_en = 1'b1; wr_tbl = 1'b0; wr_idx = ha; wr_key = k0; wr_act = 16'h0e0e; wr_vld = 1'b0;
    m_wr_ex(ha, k0, 16'h0e0e, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 lookup sees old entry", dut_res(), ex[0]);
    look("R10 write visible next", k0);

    // R10 rewrite same key together with lookup: clear wins
    prog(1'b0, ha, k0, '0, 16'h0f0f, 1'b1);
    look("R10 setup", k0);
    @(negedge clk);
    tk = k0; key_valid = 1'b1;
    ex[0] = predict(k0);
    @(negedge clk);
    key_valid = 1'b0;
    wr_en = 1'b1; wr_tbl = 1'b0; wr_idx = ha; wr_key = k0; wr_act = 16'h0f0f; wr_vld = 1'b1;
    m_wr_ex(ha, k0, 16'h0f0f, 1'b1);
    @(negedge clk);
    wr_en = 1'b0;
    chk("R10 old count reported", dut_res(), ex[0]);
    look("R10 clear beats increment", k0);

    // R1 R8 random back-to-back stream with interleaved writes
    for (int j = 0; j < 8; j++) begin
      pool[j] = rnd_key();
      if ($urandom % 2) prog(1'b0, crc5(pool[j], 5'h05), pool[j], '0, 16'(j + 16'h100), 1'b1);
      else              prog(1'b0, crc5(pool[j], 5'h09), pool[j], '0, 16'(j + 16'h200), 1'b1);
    end
    prog(1'b1, 2,  pool[0], M_ETYPE, 16'h0202, 1'b1);
    prog(1'b1, 7,  {3'd1, 268'd0}, M_PORT, 16'h0707, 1'b1);
    prog(1'b1, 12, pool[3], M_VLAN, 16'h0c0c, 1'b1);
    prog(1'b1, 20, pool[5], M_PROTO | M_PORT, 16'h1414, 1'b1);
    for (int i = 0; i < 402; i++) begin
      @(negedge clk);
      if (i >= 2) chk("R1 R8 stream result", dut_res(), ex[i-2]);
      wr_en = 1'b0;
      if (i < 400) begin
        if (($urandom % 16) == 0) begin
          int s = $urandom % 8;
          wr_en = 1'b1; wr_vld = ($urandom % 4) != 0; wr_act = 16'($urandom);
          if ($urandom % 2) begin
            wr_tbl = 1'b0; wr_key = pool[s]; wr_idx = crc5(pool[s], 5'h05);
            m_wr_ex(wr_idx, wr_key, wr_act, wr_vld);
          end else begin
            wr_tbl = 1'b1; wr_idx = 5'($urandom); wr_key = pool[s]; wr_mask = M_ETYPE;
            m_wr_wc(wr_idx, wr_key, wr_mask, wr_act, wr_vld);
          end
        end
        case ($urandom % 10)
          0, 1, 2, 3, 4: kr = pool[$urandom % 8];
          5, 6: begin kr = pool[$urandom % 8]; kr[$urandom % KW] ^= 1'b1; end
          7: begin kr = rnd_key(); kr[171:156] = pool[0][171:156]; end
          default: kr = rnd_key();
        endcase
        tk = kr; lo_o = 12'($urandom); lo_i = 12'($urandom); key_valid = 1'b1;
        ex[i] = predict(kr);
      end else begin
        key_valid = 1'b0;
      end
    end
    @(negedge clk);
    finish_run();
  end
endmodule